// File: doc/BRIEF.md
# Indirect Channel Equalizer Register Controller

This block is a word-addressed slave that lets a host reach the equalizer settings of several logical channels through a small indirect window, so the settings need no direct addresses. The host loads a channel number, a register offset inside that channel, and a data word into three window registers. It then sets a command bit in a control/status word. While the block carries the value into the chosen channel's register bank, it shows a busy flag. The host polls that flag, and must not start a new access until the flag reads 0.

Each channel holds two settings: a 2-bit control field and a 3-bit first-tap value. The control value 2'b10 means powered with adaptation off, which is manual mode. The current value of every channel's settings is driven straight onto output ports, where the equalizer logic beside the block can use it. Reads are combinational: `host_rdata` follows `host_addr` in the same cycle.

Top module: `eq_indirect_ctrl`

## Requirements
- R1: After reset, every channel control and tap output is 0, busy (bit 8 of the word at 0x1A) reads 0, and the window registers read 0.
- R2: The channel register (0x18), offset register (0x1B) and data register (0x1C) each keep the low 8 bits of the last accepted host write and read them back, with bits 31:8 reading 0.
- R3: A write to 0x1A with bit 0 set, issued while busy is 0, starts a command. Bit 8 of 0x1A then reads 1 for exactly 4 cycles following the write cycle and then returns to 0.
- R4: When a command finishes with offset 0 and a channel number below 4, data bits 1:0 are stored into that channel's control field. The field of channel i sits at `ch_ctrl[2i+1:2i]`, and every other channel keeps its value.
- R5: When a command finishes with offset 1 and a channel number below 4, data bits 2:0 are stored into that channel's tap field. The field of channel i sits at `ch_tap1[3i+2:3i]`, and every other channel keeps its value.
- R6: While busy reads 1, host writes to 0x18, 0x1B and 0x1C are ignored, and a command write to 0x1A is dropped. The dropped command neither extends nor restarts the busy period.
- R7: A channel number of 4 or more is accepted into the channel register, and a command still shows busy for 4 cycles, but no channel output changes.
- R8: A command with an offset other than 0 or 1 shows busy for 4 cycles and changes no channel output.
- R9: In the word at 0x1A, every bit except bit 8 reads 0. Any address other than 0x18, 0x1A, 0x1B or 0x1C reads 0. A write to 0x1A with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host word address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| ch_ctrl | output | 8 | Control field of each of the 4 channels, 2 bits each |
| ch_tap1 | output | 12 | First-tap field of each of the 4 channels, 3 bits each |

## Verification
The commit path is driven by random mixes of channel numbers 0 to 5, offsets 0 to 2 and random data. Each command is compared against a model kept in the bench, which tells a correct commit apart from a write into the wrong channel, the wrong field, or one that should have been discarded. Directed cases issue window writes and a second command during busy, and count how many cycles busy lasts, so that ignored and dropped accesses are separated from accesses that take effect. Further checks read back reserved bits and an unmapped address, and write the command word with bit 0 clear, which shows that nothing outside the defined fields responds.

// File: rtl/eq_indirect_pkg.sv
package eq_indirect_pkg;
  localparam logic [7:0] ADDR_CHAN = 8'h18;
  localparam logic [7:0] ADDR_CSR  = 8'h1A;
  localparam logic [7:0] ADDR_OFS  = 8'h1B;
  localparam logic [7:0] ADDR_DATA = 8'h1C;
  localparam int CSR_GO_BIT   = 0;
  localparam int CSR_BUSY_BIT = 8;

  typedef enum logic [1:0] {TGT_NONE, TGT_CTRL, TGT_TAP1} tgt_e;

  // Which per-channel register a committed command lands in.
  function automatic tgt_e decode_target(input logic [31:0] chan,
                                         input logic [31:0] ofs,
                                         input int nch);
    if (chan >= 32'(nch)) return TGT_NONE;
    if (ofs == 32'd0)     return TGT_CTRL;
    if (ofs == 32'd1)     return TGT_TAP1;
    return TGT_NONE;
  endfunction
endpackage

// File: rtl/eq_host_regs.sv
module eq_host_regs
  import eq_indirect_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int CH_W   = 8,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              busy,
  output logic [DW-1:0]     host_rdata,
  output logic [CH_W-1:0]   chan_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [DATA_W-1:0] data_q,
  output logic              go_req
);
  logic wr_ok;
  assign wr_ok  = host_wr && !busy;
  assign go_req = host_wr && (host_addr == ADDR_W'(ADDR_CSR)) && host_wdata[CSR_GO_BIT];

  wire unused_wdata_bits = ^host_wdata[DW-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      ofs_q  <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      if (host_addr == ADDR_W'(ADDR_CHAN)) chan_q <= host_wdata[CH_W-1:0];
      if (host_addr == ADDR_W'(ADDR_OFS))  ofs_q  <= host_wdata[OFS_W-1:0];
      if (host_addr == ADDR_W'(ADDR_DATA)) data_q <= host_wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(ADDR_CHAN)) host_rdata = DW'(chan_q);
    if (host_addr == ADDR_W'(ADDR_OFS))  host_rdata = DW'(ofs_q);
    if (host_addr == ADDR_W'(ADDR_DATA)) host_rdata = DW'(data_q);
    if (host_addr == ADDR_W'(ADDR_CSR))  host_rdata[CSR_BUSY_BIT] = busy;
  end
endmodule

// File: rtl/eq_cmd_seq.sv
module eq_cmd_seq #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  output logic busy,
  output logic cmd_accept,
  output logic commit_pulse
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  assign busy         = (cnt_q != '0);
  assign cmd_accept   = go_req && !busy;
  assign commit_pulse = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cmd_accept) cnt_q <= CNT_W'(BUSY_CYC);
    else if (busy)       cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/eq_chan_bank.sv
module eq_chan_bank
  import eq_indirect_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CH_W   = 8,
  parameter int CTRL_W = 2,
  parameter int TAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_valid,
  input  tgt_e              tgt,
  input  logic [CH_W-1:0]   chan,
  input  logic [CTRL_W-1:0] ctrl_val,
  input  logic [TAP_W-1:0]  tap_val,
  output logic [NCH*CTRL_W-1:0] ch_ctrl,
  output logic [NCH*TAP_W-1:0]  ch_tap1
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = commit_valid && (chan == CH_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_ctrl[i*CTRL_W +: CTRL_W] <= '0;
        ch_tap1[i*TAP_W +: TAP_W]   <= '0;
      end else if (sel) begin
        if (tgt == TGT_CTRL) ch_ctrl[i*CTRL_W +: CTRL_W] <= ctrl_val;
        if (tgt == TGT_TAP1) ch_tap1[i*TAP_W +: TAP_W]   <= tap_val;
      end
    end
  end
endmodule

// File: rtl/eq_indirect_ctrl.sv
module eq_indirect_ctrl
  import eq_indirect_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DW       = 32,
  parameter int NCH      = 4,
  parameter int CH_W     = 8,
  parameter int OFS_W    = 8,
  parameter int DATA_W   = 8,
  parameter int CTRL_W   = 2,
  parameter int TAP_W    = 3,
  parameter int BUSY_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic                  host_wr,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  output logic [NCH*CTRL_W-1:0] ch_ctrl,
  output logic [NCH*TAP_W-1:0]  ch_tap1
);
  logic [CH_W-1:0]   chan_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;
  logic go_req, busy, cmd_accept, commit_pulse, commit_valid;
  tgt_e tgt;

  assign tgt          = decode_target(32'(chan_q), 32'(ofs_q), NCH);
  assign commit_valid = commit_pulse && (tgt != TGT_NONE);

  eq_host_regs #(.ADDR_W(ADDR_W), .DW(DW), .CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .busy(busy), .host_rdata(host_rdata),
    .chan_q(chan_q), .ofs_q(ofs_q), .data_q(data_q), .go_req(go_req)
  );

  eq_cmd_seq #(.BUSY_CYC(BUSY_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .busy(busy),
    .cmd_accept(cmd_accept), .commit_pulse(commit_pulse)
  );

  eq_chan_bank #(.NCH(NCH), .CH_W(CH_W), .CTRL_W(CTRL_W), .TAP_W(TAP_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .tgt(tgt), .chan(chan_q),
    .ctrl_val(data_q[CTRL_W-1:0]), .tap_val(data_q[TAP_W-1:0]),
    .ch_ctrl(ch_ctrl), .ch_tap1(ch_tap1)
  );
endmodule

// File: rtl/eq_indirect_chk.sv
module eq_indirect_chk
  import eq_indirect_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CH_W   = 8,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 2,
  parameter int TAP_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  go_req,
  input logic                  cmd_accept,
  input logic                  commit_pulse,
  input logic                  commit_valid,
  input logic [CH_W-1:0]       chan_q,
  input logic [OFS_W-1:0]      ofs_q,
  input logic [DATA_W-1:0]     data_q,
  input logic [NCH*CTRL_W-1:0] ch_ctrl,
  input logic [NCH*TAP_W-1:0]  ch_tap1
);
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  assert_commit_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !busy);

  assert_drop_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_req) |-> !cmd_accept);

  assert_window_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(chan_q) && $stable(ofs_q) && $stable(data_q)));

  assert_outputs_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |=> ($stable(ch_ctrl) && $stable(ch_tap1)));

  assert_no_commit_bad_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && (chan_q >= CH_W'(NCH))) |-> !commit_valid);

  assert_no_commit_bad_ofs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && (ofs_q > OFS_W'(1))) |-> !commit_valid);
endmodule

bind eq_indirect_ctrl eq_indirect_chk #(
  .NCH(NCH), .CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .TAP_W(TAP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .go_req(go_req), .cmd_accept(cmd_accept),
  .commit_pulse(commit_pulse), .commit_valid(commit_valid), .chan_q(chan_q),
  .ofs_q(ofs_q), .data_q(data_q), .ch_ctrl(ch_ctrl), .ch_tap1(ch_tap1)
);

// File: tb/eq_indirect_ctrl_tb_top.sv
module eq_indirect_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [7:0]  ch_ctrl;
  logic [11:0] ch_tap1;

  int total = 0;
  int bad = 0;
  logic [1:0] m_ctrl [4];
  logic [2:0] m_tap  [4];

  eq_indirect_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ch_ctrl(ch_ctrl), .ch_tap1(ch_tap1)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_ctrl_vec();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) v[i*2 +: 2] = m_ctrl[i];
    return v;
  endfunction

  function automatic logic [11:0] exp_tap_vec();
    logic [11:0] v;
    for (int i = 0; i < 4; i++) v[i*3 +: 3] = m_tap[i];
    return v;
  endfunction

  // Model of a committed command, from R4/R5/R7/R8.
  function automatic void model_commit(input int ch, input int ofs, input logic [7:0] d);
    if (ch < 4 && ofs == 0) m_ctrl[ch] = d[1:0];
    if (ch < 4 && ofs == 1) m_tap[ch]  = d[2:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // Counts cycles that busy reads 1, sampling at each negedge.
  task automatic count_busy(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      rd(8'h1A, v);
      if (!v[8]) break;
      n++;
    end
  endtask

  task automatic check_outputs(input string req);
    @(negedge clk);
    chk(req, 32'(ch_ctrl), 32'(exp_ctrl_vec()));
    chk(req, 32'(ch_tap1), 32'(exp_tap_vec()));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int n;
    for (int i = 0; i < 4; i++) begin m_ctrl[i] = '0; m_tap[i] = '0; end
    v = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_outputs("R1");
    rd(8'h1A, v); chk("R1 busy", v, 32'h0);
    rd(8'h18, v); chk("R1 chan", v, 32'h0);
    rd(8'h1C, v); chk("R1 data", v, 32'h0);

    // R2 readback with upper bits dropped
    wr(8'h18, 32'hABCD_0102); rd(8'h18, v); chk("R2 chan", v, 32'h02);
    wr(8'h1B, 32'hFFFF_FF01); rd(8'h1B, v); chk("R2 ofs", v, 32'h01);
    wr(8'h1C, 32'h1234_5605); rd(8'h1C, v); chk("R2 data", v, 32'h05);

    // R5 directed: channel 2 tap gets 5, busy lasts 4 (R3)
    wr(8'h1A, 32'h1); count_busy(n); chk("R3 busy len", n, 4);
    model_commit(2, 1, 8'h05); check_outputs("R5 tap ch2");

    // R4 directed: manual mode 2'b10 on channel 0
    wr(8'h18, 0); wr(8'h1B, 0); wr(8'h1C, 32'h2); wr(8'h1A, 32'h1);
    count_busy(n); chk("R3 busy len", n, 4);
    model_commit(0, 0, 8'h02); check_outputs("R4 ctrl ch0");

    // R6: window writes and a second command during busy
    wr(8'h18, 1); wr(8'h1B, 1); wr(8'h1C, 32'h3);
    wr(8'h1A, 32'h1);
    wr(8'h1A, 32'h1);          // dropped, busy
    wr(8'h1C, 32'h6);          // ignored, busy
    wr(8'h18, 3);              // ignored, busy
    count_busy(n); chk("R6 no extend", n, 1);
    rd(8'h1C, v); chk("R6 data kept", v, 32'h3);
    rd(8'h18, v); chk("R6 chan kept", v, 32'h1);
    model_commit(1, 1, 8'h03); check_outputs("R6 commit old value");
    rd(8'h1A, v); chk("R6 no restart", v, 32'h0);

    // R7 out-of-range channel
    wr(8'h18, 5); wr(8'h1B, 0); wr(8'h1C, 32'h1); wr(8'h1A, 32'h1);
    count_busy(n); chk("R7 busy len", n, 4);
    rd(8'h18, v); chk("R7 chan accepted", v, 32'h5);
    check_outputs("R7 no change");

    // R8 reserved offset
    wr(8'h18, 3); wr(8'h1B, 2); wr(8'h1C, 32'h7); wr(8'h1A, 32'h1);
    count_busy(n); chk("R8 busy len", n, 4);
    check_outputs("R8 no change");

    // R9 reserved bits, unmapped address, go bit clear
    wr(8'h1A, 32'hFFFF_FFFE); rd(8'h1A, v); chk("R9 go clear", v, 32'h0);
    rd(8'h19, v); chk("R9 unmapped", v, 32'h0);
    rd(8'h00, v); chk("R9 unmapped", v, 32'h0);
    check_outputs("R9 no change");

    // Random commands
    for (int it = 0; it < 40; it++) begin
      int ch, ofs;
      logic [7:0] d;
      ch  = int'($urandom % 6);
      ofs = int'($urandom % 3);
      d   = 8'($urandom);
      wr(8'h18, 32'(ch)); wr(8'h1B, 32'(ofs)); wr(8'h1C, {24'hA5A5A5, d});
      rd(8'h1C, v); chk("R2 rand data", v, 32'(d));
      wr(8'h1A, 32'h1);
      count_busy(n); chk("R3 rand busy", n, 4);
      model_commit(ch, ofs, d);
      check_outputs("R4 R5 R7 R8 rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule